// File: doc/BRIEF.md
# Scaled Saturating Fixed-Point ALU Datapath

This block is the arithmetic core of a sample-rate signal processor that runs a fixed instruction loop. Each clock carries one instruction: an opcode, a source address, a destination address, a scale code and a few mode bits. The source operand is read through a read-only port and passes through a barrel scaler. The destination operand is read through a second port, combined with the scaled source in the ALU, and written back into the same word on the rising clock edge.

All data are 25-bit two's complement fractions, with the binary point just below the sign bit, so values lie in [-1.0, 1.0). Internally the arithmetic is carried at 28 bits so that a result outside that range can be detected. That result is then either clamped to full scale or wrapped to 25 bits. Operand addresses 0 to 39 select storage words. Address 40 selects an externally held 9-bit conversion register. Addresses 48 to 63 produce constants. Addresses 41 to 47 are empty.

The sequencer that issues instructions and the analog converter that fills the conversion register both sit outside this block.

Top module: `scaled_sat_alu`

## Requirements
- R1: A result whose destination address is 0 to 39 is stored in that word on the rising clock edge. A later instruction that names the word as its source reads the stored value back.
- R2: A source address from 48 to 63 reads as a constant. Its address bits [3:0] form data bits [24:21], and data bits [20:0] are zero, so the codes span -8/8 to +7/8. A write to one of these addresses changes nothing.
- R3: Source address 40 returns the 9-bit conversion input in data bits [24:16]. Bits [15:0] are all ones when the fill mode input is 1 and all zeros when it is 0.
- R4: Addresses 41 to 47 read as zero, and a write to them is discarded.
- R5: The source is first sign-extended to 28 bits. The scale code then shifts it as follows: 4'b1111 leaves it unshifted; 4'b1101 shifts left by 1 and 4'b1110 shifts left by 2, both filling with zeros; codes 4'b0000 to 4'b1100 shift right by code+1 places, filling with the sign bit.
- R6: The opcodes compute the following, where D is the destination and S the scaled source: 0 gives D xor S; 1 gives D and S; 3 gives abs(S); 4 gives D + abs(S); 5 gives D - S; 6 gives D + S; 7 gives S.
- R7: With saturation on, a 28-bit result at or above +1.0 becomes 25'h0FFFFFF and one below -1.0 becomes 25'h1000000.
- R8: With saturation off, an out-of-range result keeps its low 25 bits.
- R9: The active-low overflow output goes low, combinationally in the same cycle as the instruction, whenever the 28-bit result lies outside [-1.0, 1.0).
- R10: Opcode 2 (limit) writes 25'h0FFFFFF when the scaled source is non-negative and 25'h1000000 when it is negative. It drives overflow low only when opcode 7 with the same source and scale would overflow.
- R11: With the conditional input set, opcodes 6 and 7 take effect only when bit test_sel_i of the conversion input is 1. When that bit is 0, the destination is rewritten with its own value. Other opcodes ignore the conditional input.
- R12: The carry flag register holds the carry out of bit 27 of the 28-bit adder for opcodes 4, 5 and 6. Subtraction is formed as D + ~S + 1. Every other opcode clears the flag, as does an opcode 6 that was skipped.
- R13: Reset clears every storage word and the carry flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | ALU opcode |
| src_addr_i | input | 6 | Source operand address |
| dst_addr_i | input | 6 | Destination operand address |
| shift_i | input | 4 | Scale code for the source |
| sat_en_i | input | 1 | 1 selects clamping on overflow |
| cond_en_i | input | 1 | 1 makes opcodes 6 and 7 conditional |
| test_sel_i | input | 4 | Index of the conversion bit tested |
| conv_i | input | 9 | Conversion register contents |
| conv_fill_i | input | 1 | 1 reads the conversion register with its low bits set to one |
| result_o | output | 25 | Value written to the destination this cycle |
| ovf_n_o | output | 1 | Overflow, active low |
| carry_o | output | 1 | Carry flag register |

## Verification
The checks sampled on the clock edge rely on every instruction input being settled and known before that edge. They also rely on test_sel_i never pointing above bit 8 of the conversion input. The bench changes inputs only on the falling edge and keeps its test indices within 0 to 8. The write-back check further assumes that a storage address does not name a constant slot. This holds by construction, because storage and constants are kept apart by the address comparisons.

// File: rtl/sal_pkg.sv
package sal_pkg;
  localparam int DATA_W = 25;
  localparam int EXT_W  = 28;
  localparam int SH_W   = 4;

  typedef enum logic [2:0] {
    OP_XOR = 3'd0, OP_AND = 3'd1, OP_LIM = 3'd2, OP_ABS = 3'd3,
    OP_ABA = 3'd4, OP_SUB = 3'd5, OP_ADD = 3'd6, OP_LDA = 3'd7
  } alu_op_e;

  localparam logic [DATA_W-1:0] FS_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] FS_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  // widen a fraction to the guard-bit width
  function automatic logic [EXT_W-1:0] widen(input logic [DATA_W-1:0] d);
    return {{(EXT_W-DATA_W){d[DATA_W-1]}}, d};
  endfunction

  // non-linear scale code map
  function automatic logic [EXT_W-1:0] scale(input logic [EXT_W-1:0] x,
                                             input logic [SH_W-1:0] code);
    logic [EXT_W-1:0] r;
    case (code)
      4'b1111: r = x;
      4'b1101: r = x << 1;
      4'b1110: r = x << 2;
      default: r = $signed(x) >>> (code + 4'd1);
    endcase
    return r;
  endfunction

  // true when the guard bits and the sign agree
  function automatic logic in_range(input logic [EXT_W-1:0] r);
    return (&r[EXT_W-1:DATA_W-1]) | ~(|r[EXT_W-1:DATA_W-1]);
  endfunction

  function automatic logic [DATA_W-1:0] clamp(input logic [EXT_W-1:0] r);
    return r[EXT_W-1] ? FS_NEG : FS_POS;
  endfunction
endpackage

// File: rtl/sal_regfile.sv
module sal_regfile
  import sal_pkg::*;
#(
  parameter int WORDS = 40,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_a_addr,
  input  logic [AW-1:0]     rd_b_addr,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              we,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int IW = $clog2(WORDS);
  localparam logic [AW-1:0] LIMIT = AW'(WORDS);

  logic [DATA_W-1:0] mem [WORDS];
  logic [IW-1:0] wr_idx;
  assign wr_idx = wr_addr[IW-1:0];

  assign rd_a = (rd_a_addr < LIMIT) ? mem[rd_a_addr[IW-1:0]] : '0;
  assign rd_b = (rd_b_addr < LIMIT) ? mem[rd_b_addr[IW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we && wr_addr < LIMIT) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // R1
  wr_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_addr < LIMIT) |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/sal_operand_sel.sv
module sal_operand_sel
  import sal_pkg::*;
#(
  parameter int WORDS      = 40,
  parameter int AW         = 6,
  parameter int CONV_ADDR  = 40,
  parameter int CONST_BASE = 48,
  parameter int CONV_W     = 9
) (
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [CONV_W-1:0] conv,
  input  logic              conv_fill,
  output logic [DATA_W-1:0] value
);
  localparam logic [AW-1:0] LIMIT = AW'(WORDS);
  localparam logic [AW-1:0] CV_A  = AW'(CONV_ADDR);
  localparam logic [AW-1:0] K_A   = AW'(CONST_BASE);
  localparam int LOW_W = DATA_W - CONV_W;

  logic [AW-1:0] k_off;
  assign k_off = addr - K_A;

  always_comb begin
    if (addr < LIMIT)       value = reg_val;
    else if (addr == CV_A)  value = {conv, {LOW_W{conv_fill}}};
    else if (addr >= K_A)   value = {k_off[3:0], {(DATA_W-4){1'b0}}};
    else                    value = '0;
  end
endmodule

// File: rtl/sal_scaler.sv
module sal_scaler
  import sal_pkg::*;
(
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   code,
  output logic [EXT_W-1:0]  dout
);
  assign dout = scale(widen(din), code);
endmodule

// File: rtl/sal_alu.sv
module sal_alu
  import sal_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [EXT_W-1:0]  a,
  input  logic [DATA_W-1:0] b,
  input  logic              skip,
  input  logic              sat_en,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              carry
);
  logic [EXT_W-1:0] b_ext, abs_a, x, y, r;
  logic [EXT_W:0]   sum;
  logic             cin, use_add;

  assign b_ext = widen(b);
  assign abs_a = a[EXT_W-1] ? (~a + EXT_W'(1)) : a;
  assign sum   = {1'b0, x} + {1'b0, y} + {{EXT_W{1'b0}}, cin};

  always_comb begin
    x = '0; y = '0; cin = 1'b0; use_add = 1'b1;
    case (op)
      OP_ABS: y = abs_a;
      OP_ABA: begin x = b_ext; y = abs_a; end
      OP_SUB: begin x = b_ext; y = ~a; cin = 1'b1; end
      OP_ADD: begin x = b_ext; y = skip ? '0 : a; end
      OP_LDA: begin x = skip ? b_ext : '0; y = skip ? '0 : a; end
      default: use_add = 1'b0;
    endcase
  end

  always_comb begin
    case (op)
      OP_XOR:  r = b_ext ^ a;
      OP_AND:  r = b_ext & a;
      OP_LIM:  r = a;
      default: r = sum[EXT_W-1:0];
    endcase
    ovf   = ~in_range(r);
    carry = use_add & sum[EXT_W] & (op != OP_LDA);
    if (op == OP_LIM)       result = clamp(a);
    else if (ovf && sat_en) result = clamp(r);
    else                    result = r[DATA_W-1:0];
  end
endmodule

// File: rtl/scaled_sat_alu.sv
module scaled_sat_alu
  import sal_pkg::*;
#(
  parameter int WORDS      = 40,
  parameter int AW         = 6,
  parameter int CONV_ADDR  = 40,
  parameter int CONST_BASE = 48,
  parameter int CONV_W     = 9,
  parameter int TW         = $clog2(CONV_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [AW-1:0]     dst_addr_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic              sat_en_i,
  input  logic              cond_en_i,
  input  logic [TW-1:0]     test_sel_i,
  input  logic [CONV_W-1:0] conv_i,
  input  logic              conv_fill_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_n_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] reg_a, reg_b, src_val, dst_val;
  logic [EXT_W-1:0]  scaled;
  logic              test_bit, skip, ovf, carry_nxt;

  sal_regfile #(.WORDS(WORDS), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(src_addr_i), .rd_b_addr(dst_addr_i),
    .rd_a(reg_a), .rd_b(reg_b),
    .we(1'b1), .wr_addr(dst_addr_i), .wr_data(result_o)
  );

  sal_operand_sel #(.WORDS(WORDS), .AW(AW), .CONV_ADDR(CONV_ADDR),
                    .CONST_BASE(CONST_BASE), .CONV_W(CONV_W)) u_sel_a (
    .addr(src_addr_i), .reg_val(reg_a), .conv(conv_i),
    .conv_fill(conv_fill_i), .value(src_val)
  );

  sal_operand_sel #(.WORDS(WORDS), .AW(AW), .CONV_ADDR(CONV_ADDR),
                    .CONST_BASE(CONST_BASE), .CONV_W(CONV_W)) u_sel_b (
    .addr(dst_addr_i), .reg_val(reg_b), .conv(conv_i),
    .conv_fill(conv_fill_i), .value(dst_val)
  );

  sal_scaler u_scl (.din(src_val), .code(shift_i), .dout(scaled));

  assign test_bit = (32'(test_sel_i) < CONV_W) ? conv_i[test_sel_i] : 1'b0;
  assign skip     = cond_en_i & ~test_bit;

  sal_alu u_alu (
    .op(op_i), .a(scaled), .b(dst_val), .skip(skip), .sat_en(sat_en_i),
    .result(result_o), .ovf(ovf), .carry(carry_nxt)
  );

  assign ovf_n_o = ~ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_o <= 1'b0;
    else        carry_o <= carry_nxt;
  end

  // R7
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_n_o && sat_en_i) |-> (result_o == FS_POS || result_o == FS_NEG));

  // R10
  lim_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LIM) |-> (result_o == (scaled[EXT_W-1] ? FS_NEG : FS_POS)));

  // R11
  cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && (op_i == OP_ADD || op_i == OP_LDA)) |-> result_o == dst_val);

  // R12
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LDA || op_i == OP_XOR || op_i == OP_AND) |=> !carry_o);
endmodule

// File: tb/scaled_sat_alu_test.sv
module scaled_sat_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd7;
  logic [5:0]  src_addr_i = 6'd41, dst_addr_i = 6'd41;
  logic [3:0]  shift_i = 4'hF, test_sel_i = 4'd0;
  logic        sat_en_i = 1'b0, cond_en_i = 1'b0, conv_fill_i = 1'b0;
  logic [8:0]  conv_i = 9'd0;
  logic [24:0] result_o;
  logic        ovf_n_o, carry_o;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  scaled_sat_alu uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_addr_i(src_addr_i),
    .dst_addr_i(dst_addr_i), .shift_i(shift_i), .sat_en_i(sat_en_i),
    .cond_en_i(cond_en_i), .test_sel_i(test_sel_i), .conv_i(conv_i),
    .conv_fill_i(conv_fill_i), .result_o(result_o), .ovf_n_o(ovf_n_o),
    .carry_o(carry_o)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [5:0]  src;
    logic [5:0]  dst;
    logic [3:0]  sh;
    logic        sat;
    logic        cnd;
    logic [3:0]  tsel;
    logic        fill;
    logic [8:0]  conv;
    logic [24:0] exp;
    logic        ovfn;
    logic        cy;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  // op codes: 0 xor 1 and 2 lim 3 abs 4 aba 5 sub 6 add 7 lda; 41 = empty slot
  localparam vec_t TBL [NV] = '{
    '{3'd7, 6'd52, 6'd0,  4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0800000, 1'b1, 1'b0, 4'd2},  // R2
    '{3'd7, 6'd56, 6'd1,  4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h1000000, 1'b1, 1'b0, 4'd2},  // R2
    '{3'd6, 6'd52, 6'd0,  4'hF, 1'b1, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0FFFFFF, 1'b0, 1'b0, 4'd7},  // R7 R9
    '{3'd6, 6'd49, 6'd0,  4'h0, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h10FFFFF, 1'b0, 1'b0, 4'd8},  // R8
    '{3'd7, 6'd0,  6'd41, 4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h10FFFFF, 1'b1, 1'b0, 4'd1},  // R1
    '{3'd7, 6'd49, 6'd2,  4'hE, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0800000, 1'b1, 1'b0, 4'd5},  // R5
    '{3'd7, 6'd52, 6'd3,  4'hD, 1'b1, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0FFFFFF, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd2, 6'd56, 6'd4,  4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h1000000, 1'b1, 1'b0, 4'd10}, // R10
    '{3'd2, 6'd52, 6'd4,  4'hD, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0FFFFFF, 1'b0, 1'b0, 4'd10}, // R10
    '{3'd3, 6'd58, 6'd5,  4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0C00000, 1'b1, 1'b0, 4'd6},  // R6
    '{3'd4, 6'd63, 6'd5,  4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0E00000, 1'b1, 1'b0, 4'd6},  // R6
    '{3'd5, 6'd50, 6'd2,  4'h1, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0700000, 1'b1, 1'b1, 4'd12}, // R12 R6
    '{3'd0, 6'd51, 6'd2,  4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0100000, 1'b1, 1'b0, 4'd6},  // R6
    '{3'd1, 6'd56, 6'd5,  4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0000000, 1'b1, 1'b0, 4'd6},  // R6
    '{3'd7, 6'd56, 6'd41, 4'hC, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h1FFF800, 1'b1, 1'b0, 4'd5},  // R5
    '{3'd7, 6'd40, 6'd41, 4'hF, 1'b0, 1'b0, 4'd0, 1'b1, 9'h165, 25'h165FFFF, 1'b1, 1'b0, 4'd3},  // R3
    '{3'd7, 6'd40, 6'd41, 4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h1650000, 1'b1, 1'b0, 4'd3},  // R3
    '{3'd6, 6'd49, 6'd2,  4'hF, 1'b0, 1'b1, 4'd1, 1'b0, 9'h165, 25'h0100000, 1'b1, 1'b0, 4'd11}, // R11
    '{3'd6, 6'd49, 6'd2,  4'hF, 1'b0, 1'b1, 4'd2, 1'b0, 9'h165, 25'h0300000, 1'b1, 1'b0, 4'd11}, // R11
    '{3'd7, 6'd55, 6'd2,  4'hF, 1'b0, 1'b1, 4'd1, 1'b0, 9'h165, 25'h0300000, 1'b1, 1'b0, 4'd11}, // R11
    '{3'd7, 6'd2,  6'd41, 4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0300000, 1'b1, 1'b0, 4'd11}, // R11
    '{3'd7, 6'd49, 6'd52, 4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0200000, 1'b1, 1'b0, 4'd2},  // R2
    '{3'd7, 6'd52, 6'd41, 4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0800000, 1'b1, 1'b0, 4'd2},  // R2
    '{3'd7, 6'd49, 6'd45, 4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0200000, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd7, 6'd45, 6'd41, 4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0000000, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd7, 6'd3,  6'd41, 4'hF, 1'b0, 1'b0, 4'd0, 1'b0, 9'h165, 25'h0FFFFFF, 1'b1, 1'b0, 4'd1}   // R1
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input int req, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    op_i = v.op; src_addr_i = v.src; dst_addr_i = v.dst; shift_i = v.sh;
    sat_en_i = v.sat; cond_en_i = v.cnd; test_sel_i = v.tsel;
    conv_fill_i = v.fill; conv_i = v.conv;
    #3;
    check(32'(result_o), 32'(v.exp), int'(v.req), "result");
    check(32'(ovf_n_o), 32'(v.ovfn), int'(v.req), "ovf_n");
    @(posedge clk); #1;
    check(32'(carry_o), 32'(v.cy), 12, "carry");
  endtask

  task automatic read_word(input logic [5:0] a, input logic [24:0] exp, input int req);
    @(negedge clk);
    op_i = 3'd7; src_addr_i = a; dst_addr_i = 6'd41; shift_i = 4'hF;
    sat_en_i = 1'b0; cond_en_i = 1'b0; conv_fill_i = 1'b0;
    #3;
    check(32'(result_o), 32'(exp), req, "readback");
    @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    // R13: reset state
    #2 check(32'(carry_o), 32'd0, 13, "carry after reset");
    read_word(6'd7, 25'h0, 13);
    for (int i = 0; i < NV; i++) run_vec(TBL[i]);
    // R13: reset mid-run clears stored words and the flag
    @(negedge clk); rst_n = 1'b0;
    #5 rst_n = 1'b1;
    check(32'(carry_o), 32'd0, 13, "carry after second reset");
    read_word(6'd0, 25'h0, 13);
    read_word(6'd3, 25'h0, 13);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule